// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block moves pairs of 24-bit two's complement samples, one left and one right, onto a three-wire serial audio line: a bit clock, a word-select clock and a data line. It runs entirely on the system master clock. A 3-bit mode code selects one of two roles. As clock master, the block divides the master clock down to a 64-slot frame and drives both line clocks. As clock slave, it follows bit and word clocks from elsewhere through two-stage synchronisers and adapts to their slot count.

Two framings are supported. In left-justified framing the word clock is high for the left channel and the MSB occupies the first slot. In I2S framing the word clock is low for the left channel and the MSB is delayed by one slot. A new sample pair is captured at the start of every left half, so the caller may change its inputs at any time after that point. The mode code also yields a high-pass-filter enable for the neighbouring decimation path, and a role flag that the pad ring can use to turn the clock pins around.

Top module: `audio_serial_tx`

## Requirements
- R1: The mode code `mode_sel` is decoded as follows. 3'b010 selects master at 256x, 3'b011 master at 512x, 3'b110 master at 384x and 3'b111 master at 768x. Codes 3'b000, 3'b001 and 3'b100 select slave, and the reserved code 3'b101 is also treated as slave. `hpf_en` is low only for 3'b001. `master_mode` is high only for the four master codes.
- R2: In master mode `sclk_o` has a period of ratio/64 master clocks with equal high and low times. `lrck_o` changes only together with a falling edge of `sclk_o` and holds each level for 32 `sclk_o` periods.
- R3: `sdto` changes only at falling edges of the active bit clock, and each word is sent MSB first, unchanged from the input sample.
- R4: With `fmt_i2s` low, a high word clock marks the left channel and the MSB is sent in the first slot after the word clock changes.
- R5: With `fmt_i2s` high, a low word clock marks the left channel and the MSB is sent in the second slot after the word clock changes.
- R6: Every slot that carries no data bit drives `sdto` low.
- R7: In slave mode, a half-frame of fewer than 24 slots (32 bit clocks per frame) carries only the upper 16 bits of each sample. In I2S framing the sixteenth bit falls into the first slot of the next half.
- R8: In slave mode with at least 24 slots per half-frame (48 or 64 bit clocks per frame), all 24 bits are sent.
- R9: Both samples are captured when a left half begins. Input changes made during a frame do not alter the words of that frame.
- R10: While `rst_n` is low, `sdto`, `sclk_o` and `lrck_o` are low, and in slave mode `sclk_o` and `lrck_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | System master clock |
| rst_n | input | 1 | Active-low power-down and asynchronous reset |
| mode_sel | input | 3 | Mode code: role, clock ratio, filter enable |
| fmt_i2s | input | 1 | 1: I2S framing, 0: left-justified framing |
| left_sample | input | 24 | Left channel sample, two's complement |
| right_sample | input | 24 | Right channel sample, two's complement |
| sclk_i | input | 1 | External bit clock (slave mode) |
| lrck_i | input | 1 | External word clock (slave mode) |
| sclk_o | output | 1 | Generated bit clock (master mode) |
| lrck_o | output | 1 | Generated word clock (master mode) |
| sdto | output | 1 | Serial data output |
| master_mode | output | 1 | High when the decoded role is clock master |
| hpf_en | output | 1 | Decoded high-pass filter enable |

## Verification
The bench uses the default parameters: 24-bit samples, a 16-bit narrow word, a 6-bit saturating slot counter, two synchroniser stages and 32 slots per half-frame. With these values all four master divide ratios (half periods of 2, 3, 4 and 6 master clocks) and the three slave frame lengths of 64, 48 and 32 bit clocks can be reached in short runs. The slave bit clock is driven with a period of 16 master clocks, which leaves enough headroom over the synchroniser latency that the I2S tail bit of a 32-slot frame and the slot-count width detection both appear at the pins within a few frames.

// File: rtl/asp_pkg.sv
package asp_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int NARROW_W   = 16;
    localparam int SLOT_W     = 6;
    localparam int DIV_W      = 3;
    localparam int HALF_SLOTS = 32;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic             master;
        logic [DIV_W-1:0] half_div;
        logic             hpf_en;
    } mode_t;

    // Pin code to role, bit-clock half period (master clocks) and filter enable
    function automatic mode_t decode_mode(input logic [2:0] code);
        mode_t m;
        m.master   = 1'b0;
        m.half_div = DIV_W'(2);
        m.hpf_en   = 1'b1;
        case (code)
            3'b001: m.hpf_en = 1'b0;
            3'b010: begin m.master = 1'b1; m.half_div = DIV_W'(2); end
            3'b011: begin m.master = 1'b1; m.half_div = DIV_W'(4); end
            3'b110: begin m.master = 1'b1; m.half_div = DIV_W'(3); end
            3'b111: begin m.master = 1'b1; m.half_div = DIV_W'(6); end
            default: ;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/asp_bitclk_gen.sv
module asp_bitclk_gen #(
    parameter int DIV_W      = 3,
    parameter int HALF_SLOTS = 32
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             sclk_o,
    output logic             lrck_o,
    output logic             fall_o,
    output logic             lrck_nxt_o
);
    localparam int BIT_W = $clog2(HALF_SLOTS);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [BIT_W-1:0] slot;
        logic             sclk;
        logic             lrck;
    } gen_t;

    localparam gen_t GEN_RST = '{cnt: '0, slot: '1, sclk: 1'b0, lrck: 1'b0};

    gen_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fall_o = 1'b0;
        if (!en_i) begin
            st_d = GEN_RST;
        end else if (st_q.cnt == half_i - DIV_W'(1)) begin
            st_d.cnt  = '0;
            st_d.sclk = ~st_q.sclk;
            if (st_q.sclk) begin
                fall_o    = 1'b1;
                st_d.slot = st_q.slot + BIT_W'(1);
                if (&st_q.slot) begin
                    st_d.lrck = ~st_q.lrck;
                end
            end
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
        lrck_nxt_o = st_d.lrck;
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= GEN_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o = st_q.sclk;
    assign lrck_o = st_q.lrck;

    // R2: word clock moves only with a bit clock falling edge
    p_lrck_on_fall_r2: assert property (@(posedge mclk) disable iff (!rst_n)
        (en_i && $past(en_i) && (lrck_o != $past(lrck_o))) |-> ($past(sclk_o) && !sclk_o));

    // R2: every bit clock high phase lasts at least two master clocks
    p_sclk_hold_r2: assert property (@(posedge mclk) disable iff (!rst_n)
        (en_i && $past(en_i) && $rose(sclk_o)) |=> (!en_i || $stable(sclk_o)));

endmodule

// File: rtl/asp_in_sync.sv
module asp_in_sync #(
    parameter int STAGES = 2
) (
    input  logic mclk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic lrck_i,
    output logic fall_o,
    output logic lrck_o
);
    typedef struct packed {
        logic [STAGES:0]   sck;
        logic [STAGES-1:0] lr;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sck = {st_q.sck[STAGES-1:0], sclk_i};
        st_d.lr  = {st_q.lr[STAGES-2:0], lrck_i};
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The last word clock stage lines up with the newer of the two bit clock taps
    assign fall_o = st_q.sck[STAGES] & ~st_q.sck[STAGES-1];
    assign lrck_o = st_q.lr[STAGES-1];

endmodule

// File: rtl/asp_frame_shifter.sv
module asp_frame_shifter #(
    parameter int SAMPLE_W = 24,
    parameter int NARROW_W = 16,
    parameter int SLOT_W   = 6
) (
    input  logic                mclk,
    input  logic                rst_n,
    input  logic                fall_i,
    input  logic                lrck_i,
    input  logic                i2s_i,
    input  logic                narrow_ok_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                sdto_o
);
    localparam logic [SLOT_W:0]   NB_WIDE   = (SLOT_W+1)'(SAMPLE_W);
    localparam logic [SLOT_W:0]   NB_NARROW = (SLOT_W+1)'(NARROW_W);
    localparam logic [SLOT_W:0]   POS_ONE   = (SLOT_W+1)'(1);
    localparam logic [SLOT_W-1:0] WIDE_LAST = SLOT_W'(SAMPLE_W-1);

    typedef struct packed {
        logic                lrck_seen;
        logic [SLOT_W-1:0]   slot;
        logic                narrow;
        logic [SAMPLE_W-1:0] word;
        logic [SAMPLE_W-1:0] shadow_r;
        logic                sdto;
    } shf_t;

    shf_t st_d, st_q;

    logic [SLOT_W:0] nb, pos, dly;
    logic            left, is_edge;

    function automatic logic bit_at(input logic [SAMPLE_W-1:0] w, input logic [SLOT_W:0] p);
        logic [SAMPLE_W-1:0] s;
        s = w << p;
        return s[SAMPLE_W-1];
    endfunction

    always_comb begin
        st_d    = st_q;
        dly     = {{SLOT_W{1'b0}}, i2s_i};
        nb      = st_q.narrow ? NB_NARROW : NB_WIDE;
        pos     = '0;
        left    = i2s_i ? ~lrck_i : lrck_i;
        is_edge = fall_i && (lrck_i != st_q.lrck_seen);
        if (is_edge) begin
            // width of the half just ended decides narrow or wide words
            st_d.narrow    = narrow_ok_i && (st_q.slot < WIDE_LAST);
            st_d.lrck_seen = lrck_i;
            st_d.slot      = '0;
            nb             = st_d.narrow ? NB_NARROW : NB_WIDE;
            pos            = {1'b0, st_q.slot} + POS_ONE - dly;
            if (left) begin
                st_d.word     = left_i;
                st_d.shadow_r = right_i;
            end else begin
                st_d.word     = st_q.shadow_r;
            end
            if (i2s_i) begin
                // first slot of a half carries the delayed tail of the previous word
                st_d.sdto = (pos < nb) ? bit_at(st_q.word, pos) : 1'b0;
            end else begin
                st_d.sdto = st_d.word[SAMPLE_W-1];
            end
        end else if (fall_i) begin
            if (st_q.slot != '1) begin
                st_d.slot = st_q.slot + SLOT_W'(1);
            end
            pos       = {1'b0, st_d.slot} - dly;
            st_d.sdto = (({1'b0, st_d.slot} >= dly) && (pos < nb)) ? bit_at(st_q.word, pos) : 1'b0;
        end
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lrck_seen: 1'b0, slot: '1, narrow: 1'b0, word: '0, shadow_r: '0, sdto: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sdto_o = st_q.sdto;

    // R3: data line moves only on a bit clock falling edge
    p_sdto_on_fall_r3: assert property (@(posedge mclk) disable iff (!rst_n)
        (sdto_o != $past(sdto_o)) |-> $past(fall_i));

    // R9: the right sample held for a frame is only replaced at a bit clock edge event
    p_shadow_frame_r9: assert property (@(posedge mclk) disable iff (!rst_n)
        (st_q.shadow_r != $past(st_q.shadow_r)) |-> ($past(fall_i) && ($past(lrck_i) != $past(st_q.lrck_seen))));

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
    import asp_pkg::*;
#(
    parameter int SAMPLE_W = asp_pkg::SAMPLE_W
) (
    input  logic                mclk,
    input  logic                rst_n,
    input  logic [2:0]          mode_sel,
    input  logic                fmt_i2s,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic [SAMPLE_W-1:0] right_sample,
    input  logic                sclk_i,
    input  logic                lrck_i,
    output logic                sclk_o,
    output logic                lrck_o,
    output logic                sdto,
    output logic                master_mode,
    output logic                hpf_en
);
    mode_t mode;
    logic  gen_fall, gen_lrck_nxt;
    logic  syn_fall, syn_lrck;
    logic  bit_fall, word_clk;

    assign mode        = decode_mode(mode_sel);
    assign master_mode = mode.master;
    assign hpf_en      = mode.hpf_en;

    asp_bitclk_gen #(
        .DIV_W      (DIV_W),
        .HALF_SLOTS (HALF_SLOTS)
    ) u_gen (
        .mclk       (mclk),
        .rst_n      (rst_n),
        .en_i       (mode.master),
        .half_i     (mode.half_div),
        .sclk_o     (sclk_o),
        .lrck_o     (lrck_o),
        .fall_o     (gen_fall),
        .lrck_nxt_o (gen_lrck_nxt)
    );

    asp_in_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .mclk   (mclk),
        .rst_n  (rst_n),
        .sclk_i (sclk_i),
        .lrck_i (lrck_i),
        .fall_o (syn_fall),
        .lrck_o (syn_lrck)
    );

    assign bit_fall = mode.master ? gen_fall     : syn_fall;
    assign word_clk = mode.master ? gen_lrck_nxt : syn_lrck;

    asp_frame_shifter #(
        .SAMPLE_W (SAMPLE_W),
        .NARROW_W (NARROW_W),
        .SLOT_W   (SLOT_W)
    ) u_shf (
        .mclk        (mclk),
        .rst_n       (rst_n),
        .fall_i      (bit_fall),
        .lrck_i      (word_clk),
        .i2s_i       (fmt_i2s),
        .narrow_ok_i (~mode.master),
        .left_i      (left_sample),
        .right_i     (right_sample),
        .sdto_o      (sdto)
    );

    // R10: generated clocks stay quiet while following external clocks
    p_slave_quiet_r10: assert property (@(posedge mclk) disable iff (!rst_n)
        (!mode.master && $past(!mode.master)) |-> (!sclk_o && !lrck_o));

endmodule

// File: tb/audio_serial_tx_tb.sv
module audio_serial_tx_tb;

    logic        mclk = 1'b0;
    logic        rst_n;
    logic [2:0]  mode_sel;
    logic        fmt_i2s;
    logic [23:0] left_sample, right_sample;
    logic        sclk_drv, lrck_drv;
    logic        sclk_o, lrck_o, sdto, master_mode, hpf_en;

    always #4 mclk = ~mclk;

    audio_serial_tx u_dut (
        .mclk         (mclk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .fmt_i2s      (fmt_i2s),
        .left_sample  (left_sample),
        .right_sample (right_sample),
        .sclk_i       (sclk_drv),
        .lrck_i       (lrck_drv),
        .sclk_o       (sclk_o),
        .lrck_o       (lrck_o),
        .sdto         (sdto),
        .master_mode  (master_mode),
        .hpf_en       (hpf_en)
    );

    int    checks = 0;
    int    errors = 0;
    bit    cfg_master, cfg_i2s;
    int    cfg_nbits;
    string cfg_tag;
    bit    mon_en = 0;
    logic  bclk, blrck;
    assign bclk  = cfg_master ? sclk_o : sclk_drv;
    assign blrck = cfg_master ? lrck_o : lrck_drv;

    logic [47:0] exp_q[$];
    event        frame_ev;
    int          pat_n;

    int          cnt, rises, cur_frame, frame_idx;
    logic        last_lr, cur_left, pair_ok, pad_bad;
    logic [23:0] rx_word;
    logic [47:0] cur_pair;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] pat(input int n);
        case (n % 6)
            0:       return 24'h800000;
            1:       return 24'h7FFFFF;
            2:       return 24'hFFFFFF;
            3:       return 24'h000001;
            default: return 24'(n * 32'h0013579B ^ 32'h00A5C3E1);
        endcase
    endfunction

    // driver: records the pair the block just captured, then presents the next one
    initial begin
        forever begin
            @(frame_ev);
            exp_q.push_back({left_sample, right_sample});
            pat_n++;
            left_sample  = pat(pat_n);
            right_sample = pat(pat_n * 7 + 2) ^ 24'h5A5A5A;
        end
    end

    task automatic put_bit(input logic b);
        int k;
        k = cnt - (cfg_i2s ? 1 : 0);
        if (k >= 0) begin
            if (k < cfg_nbits) rx_word[23-k] = b;
            else if (b) pad_bad = 1'b1;
        end
        cnt++;
    endtask

    task automatic finish_half();
        logic [23:0] exp;
        if (cur_left && cur_frame >= 0) begin
            pair_ok = (exp_q.size() > 0);
            if (pair_ok) cur_pair = exp_q.pop_front();
        end
        if (cur_frame >= 1 && pair_ok) begin
            exp = cur_left ? cur_pair[47:24] : cur_pair[23:0];
            if (cfg_nbits == 16) exp[7:0] = 8'h00;
            check(rx_word == exp, cfg_tag, cur_left ? "left word" : "right word",
                  32'(rx_word), 32'(exp));
            check(!pad_bad, "R6", "idle slot driven high", 32'(pad_bad), 0);
            if (cfg_master) check(rises == 32, "R2", "bit clocks per half", rises, 32);
        end
    endtask

    task automatic mon_clear();
        cnt = 0; rises = 0; cur_frame = -1; frame_idx = -1;
        last_lr = 1'b0; cur_left = 1'b0; pair_ok = 1'b0; pad_bad = 1'b0;
        rx_word = '0; cur_pair = '0;
    endtask

    // monitor: deserialises the line at each bit clock rise
    initial begin
        logic lr, b;
        mon_clear();
        forever begin
            @(posedge bclk);
            #1;
            if (mon_en) begin
                lr = blrck;
                b  = sdto;
                if (lr !== last_lr) begin
                    if (cfg_i2s) put_bit(b);
                    finish_half();
                    last_lr  = lr;
                    cnt      = 0;
                    rx_word  = '0;
                    pad_bad  = 1'b0;
                    cur_left = cfg_i2s ? !lr : lr;
                    if (cur_left) begin
                        frame_idx++;
                        -> frame_ev;
                    end
                    cur_frame = frame_idx;
                    if (cfg_i2s) cnt = 1;
                    else put_bit(b);
                    rises = 1;
                end else begin
                    put_bit(b);
                    rises++;
                end
            end
        end
    end

    task automatic start_case(input logic [2:0] code, input bit i2s, input bit mst,
                              input int nbits, input string tag);
        @(negedge mclk);
        rst_n = 1'b0;
        mon_en = 0;
        mode_sel = code; fmt_i2s = i2s;
        cfg_master = mst; cfg_i2s = i2s; cfg_nbits = nbits; cfg_tag = tag;
        sclk_drv = 1'b0; lrck_drv = 1'b0;
        exp_q.delete();
        pat_n++;
        left_sample  = pat(pat_n);
        right_sample = pat(pat_n + 4) ^ 24'h3C3C3C;
        repeat (4) @(negedge mclk);
        mon_clear();
        mon_en = 1;
        rst_n  = 1'b1;
    endtask

    task automatic measure_sclk(input int period, input string req);
        int hi, tot;
        @(posedge sclk_o);
        @(negedge mclk);
        hi = 0; tot = 0;
        while (sclk_o) begin hi++; @(negedge mclk); end
        while (!sclk_o) begin tot++; @(negedge mclk); end
        tot += hi;
        check(tot == period, req, "bit clock period", tot, period);
        check(hi * 2 == period, "R2", "bit clock high time", hi, period / 2);
    endtask

    task automatic run_master(input logic [2:0] code, input bit i2s, input int period,
                              input string tag);
        start_case(code, i2s, 1, 24, tag);
        wait (frame_idx >= 6);
        measure_sclk(period, "R1");
        repeat (2) @(negedge mclk);
        mon_en = 0;
    endtask

    task automatic run_slave(input logic [2:0] code, input bit i2s, input int slots,
                             input string tag);
        logic lvl;
        start_case(code, i2s, 0, (slots < 24) ? 16 : 24, tag);
        lvl = i2s ? 1'b0 : 1'b1;
        for (int f = 0; f < 7; f++) begin
            for (int h = 0; h < 2; h++) begin
                for (int s = 0; s < slots; s++) begin
                    sclk_drv = 1'b0;
                    if (s == 0) lrck_drv = (h == 0) ? lvl : ~lvl;
                    repeat (8) @(negedge mclk);
                    sclk_drv = 1'b1;
                    repeat (8) @(negedge mclk);
                    if (sclk_o || lrck_o)
                        check(0, "R10", "generated clocks active in slave",
                              {sclk_o, lrck_o}, 0);
                end
            end
        end
        check(!sclk_o && !lrck_o, "R10", "generated clocks in slave", {sclk_o, lrck_o}, 0);
        mon_en = 0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge mclk);
        check(0, "watchdog", "run did not complete", 0, 1);
        summary();
    end

    initial begin
        logic m_exp, h_exp;
        pat_n = 0;
        rst_n = 1'b0;
        mode_sel = 3'b010; fmt_i2s = 1'b0;
        left_sample = '0; right_sample = '0;
        sclk_drv = 1'b0; lrck_drv = 1'b0;
        cfg_master = 1; cfg_i2s = 0; cfg_nbits = 24; cfg_tag = "R4";
        repeat (5) @(negedge mclk);
        check(!sdto,   "R10", "sdto in power-down",   sdto,   0);
        check(!sclk_o, "R10", "sclk_o in power-down", sclk_o, 0);
        check(!lrck_o, "R10", "lrck_o in power-down", lrck_o, 0);

        // R1: all eight mode codes
        for (int c = 0; c < 8; c++) begin
            mode_sel = 3'(c);
            #1;
            m_exp = (c == 2 || c == 3 || c == 6 || c == 7);
            h_exp = (c != 1);
            check(master_mode == m_exp, "R1", "master_mode", master_mode, m_exp);
            check(hpf_en == h_exp,      "R1", "hpf_en",      hpf_en,      h_exp);
        end

        run_master(3'b010, 1'b0, 4,  "R3/R4/R9");
        run_master(3'b011, 1'b1, 8,  "R3/R5/R9");
        run_master(3'b110, 1'b0, 6,  "R3/R4/R9");
        run_master(3'b111, 1'b1, 12, "R3/R5/R9");

        // R10: asynchronous power-down in the middle of a master frame
        @(negedge mclk);
        rst_n = 1'b0;
        #1;
        check(!sdto && !sclk_o && !lrck_o, "R10", "outputs after power-down entry",
              {sdto, sclk_o, lrck_o}, 0);

        run_slave(3'b000, 1'b0, 32, "R8/R4/R9");
        run_slave(3'b001, 1'b1, 24, "R8/R5/R9");
        run_slave(3'b100, 1'b0, 16, "R7/R4/R9");
        run_slave(3'b101, 1'b1, 16, "R7/R5/R9");

        @(negedge mclk);
        rst_n = 1'b0;
        summary();
    end

endmodule